// File: doc/BRIEF.md
# Alternate-Space-Inversion Line Encoder

This block turns a serial bit stream into drive signals for a two-rail, transformer-coupled line that uses pseudo-ternary coding with full-width pulses. A one is sent as silence: both rails float for the whole bit. A zero is sent as a pulse, and successive zeros take opposite polarities. The positive rail pushes current for a positive zero and the negative rail pushes current for a negative zero. Each rail has its own data and output-enable pin, so the pad ring can put both rails into high impedance.

Bits arrive on a valid/ready interface that is paced by a bit-rate enable pulse, one cycle wide at the 192 kHz line rate. `in_ready_o` is high only in a bit-enable cycle. A bit is taken when `in_valid_i` and `in_ready_o` are both high. A source that is not ready leaves the line idle, and an idle slot is sent as a one. Back-pressure is therefore fixed by the line rate: the source may hold `in_valid_i` high for as long as it needs, and only the enable cycle consumes its bit.

A pair of test inputs can force the polarity of zeros. A registered self-check flag marks any zero that leaves with the same polarity as the zero before it. The flag can only rise when the polarity is forced.

Top module: `asi_line_encoder`

## Requirements
- R1: `in_ready_o` equals `bit_en_i`. A bit is consumed only in a cycle where `in_valid_i` and `bit_en_i` are both high. A bit-enable cycle without `in_valid_i` is sent as a one.
- R2: A one (`in_bit_i`=1) is sent with `pos_oe_o`=0 and `neg_oe_o`=0 and both rail data at 0, for the whole bit.
- R3: A positive zero drives `pos_rail_o`=1 and `neg_rail_o`=0, with both enables at 1.
- R4: A negative zero drives `pos_rail_o`=0 and `neg_rail_o`=1, with both enables at 1.
- R5: Successive zeros alternate in polarity. Ones and idle slots between them do not change the polarity.
- R6: While reset is high and after it, all four rail outputs and `pol_err_o` read 0. The first zero after reset is positive.
- R7: The outputs change only at the clock edge that ends a bit-enable cycle. They then hold for the full bit, so a pulse fills the whole bit period.
- R8: While `test_pol_en_i` is high, a zero takes the polarity `test_pol_val_i` (1 means positive). The next unforced zero takes the opposite of that forced zero.
- R9: `pol_err_o` is 1 for the bit of a zero whose polarity matches the previous zero, and 0 for every other bit.
- R10: Values on `in_valid_i` and `in_bit_i` outside bit-enable cycles have no effect on the outputs or on the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_en_i | input | 1 | Bit-rate enable, one cycle per bit |
| in_valid_i | input | 1 | Source has a bit |
| in_bit_i | input | 1 | Bit to send |
| in_ready_o | output | 1 | Bit taken this cycle if valid |
| test_pol_en_i | input | 1 | Force zero polarity |
| test_pol_val_i | input | 1 | Forced polarity, 1 = positive |
| pos_rail_o | output | 1 | Positive rail data |
| pos_oe_o | output | 1 | Positive rail output enable |
| neg_rail_o | output | 1 | Negative rail data |
| neg_oe_o | output | 1 | Negative rail output enable |
| pol_err_o | output | 1 | Same-polarity zero detected |

## Verification
A bit taken in a bit-enable cycle appears on the rails and on `pol_err_o` after the next rising clock edge, one register stage later. It stays there until the edge after the next bit-enable cycle. The bench drives inputs on falling edges and notes at each rising edge whether the enable was high. On the following falling edge it takes the next expected symbol from the scoreboard queue. Every falling edge between enables compares the outputs against the held symbol, so glitches inside a bit and early or late updates are both caught.

// File: rtl/asi_pkg.sv
package asi_pkg;
  typedef enum logic [1:0] {
    SYM_MARK = 2'b00,
    SYM_POS  = 2'b01,
    SYM_NEG  = 2'b10
  } line_sym_e;
endpackage

// File: rtl/asi_polarity_tracker.sv
module asi_polarity_tracker
  import asi_pkg::*;
#(
  parameter bit FIRST_POS = 1'b1
) (
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      take_i,
  input  logic      bit_i,
  input  logic      force_en_i,
  input  logic      force_val_i,
  output line_sym_e sym_o
);
  logic pol_q;      // 1: next zero goes out positive
  logic zero_take;
  logic cur_pol;

  assign zero_take = take_i && !bit_i;
  assign cur_pol   = force_en_i ? force_val_i : pol_q;

  always_comb begin
    if (!zero_take) sym_o = SYM_MARK;
    else            sym_o = cur_pol ? SYM_POS : SYM_NEG;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)          pol_q <= FIRST_POS;
    else if (zero_take) pol_q <= !cur_pol;
  end

  // R5: an unforced zero flips the stored polarity
  a_r5_zero_toggles: assert property (@(posedge clk_i) disable iff (rst_i)
    (zero_take && !force_en_i) |=> (pol_q != $past(pol_q)));
  // R5: a one leaves the stored polarity untouched
  a_r5_mark_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    (take_i && bit_i) |=> $stable(pol_q));
endmodule

// File: rtl/asi_rail_driver.sv
module asi_rail_driver
  import asi_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      bit_en_i,
  input  line_sym_e sym_i,
  output logic      pos_rail_o,
  output logic      pos_oe_o,
  output logic      neg_rail_o,
  output logic      neg_oe_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pos_rail_o <= 1'b0;
      neg_rail_o <= 1'b0;
      pos_oe_o   <= 1'b0;
      neg_oe_o   <= 1'b0;
    end else if (bit_en_i) begin
      unique case (sym_i)
        SYM_POS: begin
          pos_rail_o <= 1'b1; neg_rail_o <= 1'b0;
          pos_oe_o   <= 1'b1; neg_oe_o   <= 1'b1;
        end
        SYM_NEG: begin
          pos_rail_o <= 1'b0; neg_rail_o <= 1'b1;
          pos_oe_o   <= 1'b1; neg_oe_o   <= 1'b1;
        end
        default: begin
          pos_rail_o <= 1'b0; neg_rail_o <= 1'b0;
          pos_oe_o   <= 1'b0; neg_oe_o   <= 1'b0;
        end
      endcase
    end
  end

  // R2: a mark floats both rails
  a_r2_mark_floats: assert property (@(posedge clk_i) disable iff (rst_i)
    (bit_en_i && sym_i == SYM_MARK) |=> (!pos_oe_o && !neg_oe_o));
  // R3 / R4: an enabled pair always carries opposite data
  a_r3_rails_opposite: assert property (@(posedge clk_i) disable iff (rst_i)
    pos_oe_o |-> ((pos_rail_o != neg_rail_o) && neg_oe_o));
  // R7: nothing moves inside a bit
  a_r7_hold_in_bit: assert property (@(posedge clk_i) disable iff (rst_i)
    !bit_en_i |=> $stable({pos_rail_o, neg_rail_o, pos_oe_o, neg_oe_o}));
endmodule

// File: rtl/asi_violation_mon.sv
module asi_violation_mon
  import asi_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      bit_en_i,
  input  line_sym_e sym_i,
  output logic      err_o
);
  logic last_pos_q;
  logic seen_zero_q;
  logic is_pulse;
  logic is_pos;

  assign is_pulse = (sym_i != SYM_MARK);
  assign is_pos   = (sym_i == SYM_POS);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      last_pos_q  <= 1'b0;
      seen_zero_q <= 1'b0;
      err_o       <= 1'b0;
    end else if (bit_en_i) begin
      if (is_pulse) begin
        err_o       <= seen_zero_q && (is_pos == last_pos_q);
        last_pos_q  <= is_pos;
        seen_zero_q <= 1'b1;
      end else begin
        err_o <= 1'b0;
      end
    end
  end

  // R9: the flag never rises on a mark
  a_r9_no_err_on_mark: assert property (@(posedge clk_i) disable iff (rst_i)
    (bit_en_i && !is_pulse) |=> !err_o);
endmodule

// File: rtl/asi_line_encoder.sv
module asi_line_encoder
  import asi_pkg::*;
#(
  parameter bit FIRST_POS = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bit_en_i,
  input  logic in_valid_i,
  input  logic in_bit_i,
  output logic in_ready_o,
  input  logic test_pol_en_i,
  input  logic test_pol_val_i,
  output logic pos_rail_o,
  output logic pos_oe_o,
  output logic neg_rail_o,
  output logic neg_oe_o,
  output logic pol_err_o
);
  line_sym_e sym;
  logic      take;

  assign in_ready_o = bit_en_i;
  assign take       = in_valid_i && bit_en_i;

  asi_polarity_tracker #(.FIRST_POS(FIRST_POS)) pol_i (
    .clk_i(clk_i), .rst_i(rst_i), .take_i(take), .bit_i(in_bit_i),
    .force_en_i(test_pol_en_i), .force_val_i(test_pol_val_i), .sym_o(sym)
  );

  asi_rail_driver drv_i (
    .clk_i(clk_i), .rst_i(rst_i), .bit_en_i(bit_en_i), .sym_i(sym),
    .pos_rail_o(pos_rail_o), .pos_oe_o(pos_oe_o),
    .neg_rail_o(neg_rail_o), .neg_oe_o(neg_oe_o)
  );

  asi_violation_mon mon_i (
    .clk_i(clk_i), .rst_i(rst_i), .bit_en_i(bit_en_i), .sym_i(sym),
    .err_o(pol_err_o)
  );

  // R9: a flagged bit is always a driven pulse
  a_r9_err_on_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    pol_err_o |-> pos_oe_o);
  // R10: outside enable cycles nothing on the input moves the rails
  a_r10_off_cycle_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    (!bit_en_i && in_valid_i) |=> $stable({pos_rail_o, neg_rail_o, pol_err_o}));
endmodule

// File: tb/asi_line_encoder_tb.sv
module asi_line_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_GAP   = 3;

  typedef struct {
    logic  p_oe, n_oe, p, n, err;
    string req;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic bit_en = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic tp_en = 1'b0, tp_val = 1'b0;
  logic in_ready, pos_rail, pos_oe, neg_rail, neg_oe, pol_err;

  int n_cmp = 0, n_bad = 0;
  exp_t q[$];
  exp_t cur;
  logic mdl_pol = 1'b1, mdl_last = 1'b0, mdl_seen = 1'b0;
  bit   running = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asi_line_encoder dut_i (
    .clk_i(clk), .rst_i(rst), .bit_en_i(bit_en), .in_valid_i(in_valid),
    .in_bit_i(in_bit), .in_ready_o(in_ready), .test_pol_en_i(tp_en),
    .test_pol_val_i(tp_val), .pos_rail_o(pos_rail), .pos_oe_o(pos_oe),
    .neg_rail_o(neg_rail), .neg_oe_o(neg_oe), .pol_err_o(pol_err)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: off-cycles carry junk (R10), then one enable cycle
  task automatic slot(input logic v, input logic b, input logic fen,
                      input logic fval, input string req);
    exp_t e;
    for (int i = 0; i < SLOT_GAP; i++) begin
      @(negedge clk);
      bit_en = 1'b0; in_valid = 1'b1; in_bit = 1'b0; tp_en = 1'b1; tp_val = mdl_pol;
    end
    @(negedge clk);
    bit_en = 1'b1; in_valid = v; in_bit = b; tp_en = fen; tp_val = fval;
    e.req = req;
    if (v && !b) begin
      logic p;
      p = fen ? fval : mdl_pol;
      e.err = mdl_seen && (p == mdl_last);
      mdl_last = p; mdl_seen = 1'b1; mdl_pol = !p;
      e.p_oe = 1'b1; e.n_oe = 1'b1; e.p = p; e.n = !p;
    end else begin
      e = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req};
    end
    q.push_back(e);
    @(negedge clk);
    bit_en = 1'b0; in_valid = 1'b0; tp_en = 1'b0;
  endtask

  // Monitor: pop at the falling edge after an enable edge, compare every cycle
  initial begin
    cur = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6"};
    forever begin
      logic en;
      @(posedge clk);
      en = bit_en;
      @(negedge clk);
      if (running) begin
        if (en && q.size() > 0) cur = q.pop_front();
        check({cur.req, "/R7"}, {pos_oe, neg_oe, pos_rail, neg_rail, pol_err},
              {cur.p_oe, cur.n_oe, cur.p, cur.n, cur.err});
        check("R1", {4'b0, in_ready}, {4'b0, bit_en});
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R6", {pos_oe, neg_oe, pos_rail, neg_rail, pol_err}, 5'b0);
        rst = 1'b0;
        running = 1'b1;
        slot(1, 0, 0, 0, "R3");   // first zero positive (R6)
        slot(1, 0, 0, 0, "R4");
        slot(1, 1, 0, 0, "R2");
        slot(1, 0, 0, 0, "R5");   // positive after a one
        slot(0, 0, 0, 0, "R1");   // idle slot is a mark
        slot(1, 1, 0, 0, "R2");
        slot(1, 0, 0, 0, "R5");   // negative
        slot(1, 0, 1, 0, "R9");   // forced negative again: flagged
        slot(1, 0, 0, 0, "R8");   // unforced follows forced -> positive
        slot(1, 0, 1, 1, "R9");   // forced positive again: flagged
        slot(1, 0, 1, 0, "R8");
        slot(1, 1, 1, 1, "R2");   // force has no effect on a one
        for (int k = 0; k < 20; k++)
          slot(1, k[0] ^ k[2], 0, 0, "R5");
        slot(1, 1, 0, 0, "R10");
        repeat (SLOT_GAP + 2) @(negedge clk);
        running = 1'b0;
        if (q.size() != 0) check("R7", 5'(q.size()), 5'b0);
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_cmp++; n_bad++;
          $display("FAIL watchdog: act=timeout exp=done");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule